// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects sixteen interrupt sources onto ten vectors. It ranks them across three priority tiers and hands one vector address at a time to a processor. Four external pins pass through a synchronizer and a trigger stage whose modes can be selected. Twelve on-chip request strobes set pending flags directly.

Each vector has an enable bit and one priority-select bit. The meaning of the select bit depends on the vector, so the two top external pins can never be placed in the lowest tier. The processor takes an interrupt with an acknowledge strobe and finishes it with a return strobe. A small stack of in-service levels lets a higher tier preempt a lower one. It also keeps an equal or lower tier from interrupting the current handler.

A separate wake output reports any enabled request, so a halted core can resume even when the request is masked by the level in service.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `irq_o` and `wake_o` are 0, `vec_addr_o` is 00h, the in-service stack is empty and no flag is pending.
- R2: External pins pass through a two-stage synchronizer. An edge on a pin in an edge mode sets its pending flag, and the request shows on `irq_o` after the third rising clock edge that follows the pin change.
- R3: Pins 0 and 1 use the two-bit mode field `trig_mode_i[2p+1:2p]`, where 00 is rising edge, 01 is falling edge, 10 is high level and 11 is low level. In a level mode the request follows the synchronized pin, is never latched, and appears or clears two rising edges after the pin changes.
- R4: Pins 2 and 3 use the same field position, where 00 is rising edge, 01 is falling edge, and 10 or 11 is both edges. These pins have no level mode.
- R5: Each vector collects its sources as follows. Pin p maps to vector p+1. `src_i` bit 0 maps to vector 3, bit 1 to vector 4, bit 2 to vector 5, bits 3 and 4 to vector 6, bit 5 to vector 7, bit 6 to vector 8, bits 7 to 9 to vector 9, and bits 10 and 11 to vector 10. A high strobe sets the pending flag at the next rising edge.
- R6: For vectors 1 and 2, `vec_prio_i` bit 0 selects high and bit 1 selects highest. For vectors 3 to 10, bit 0 selects low and bit 1 selects high. The tiers rank highest over high over low.
- R7: The presented vector is the enabled request with the highest tier, and the lowest vector number wins a tie. A request is presented only if its tier is strictly above the tier on top of the in-service stack, where an empty stack counts as below low.
- R8: `vec_addr_o` is 03h + 8*(n-1) for presented vector n (03h, 0Bh, ..., 4Bh). It is 00h while `irq_o` is 0.
- R9: An `ack_i` while `irq_o` is 1 clears the presented vector's edge flag and pushes its tier. `ret_i` pops one tier. An `ack_i` while `irq_o` is 0, or in the same cycle as `ret_i`, has no effect, and `ret_i` on an empty stack has no effect.
- R10: `wake_o` is 1 whenever any enabled vector has a request, regardless of tier or the tier in service.
- R11: A pending flag on a disabled vector is kept and drives neither output. It is presented once its enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin_i | input | 4 | Raw external interrupt pins (asynchronous) |
| src_i | input | 12 | On-chip request strobes |
| trig_mode_i | input | 8 | Two-bit trigger mode per external pin |
| vec_en_i | input | 10 | Enable per vector, bit n-1 for vector n |
| vec_prio_i | input | 10 | Priority select per vector |
| ack_i | input | 1 | Processor accepts the presented vector |
| ret_i | input | 1 | Processor leaves the current handler |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_addr_o | output | 8 | Vector address of the presented request |
| wake_o | output | 1 | Halt-release signal |

## Verification
The latencies differ by input type:
- An on-chip strobe reaches `irq_o` one rising edge after it is sampled.
- An external edge takes three rising edges.
- A level-mode pin takes two rising edges, both to assert and to clear.
- Changes to enable, priority or mode act combinationally on the outputs, and acknowledge and return act at the next rising edge.

The bench drives every input just after a falling edge and advances its reference model at the rising edge. It compares `irq_o`, `vec_addr_o` and `wake_o` at the following falling edge, so every expected value lines up with the register that produces it. Directed checks count edges explicitly and sample the cycle before and the cycle of each expected change.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int NUM_VEC = 10;
    localparam int NUM_PIN = 4;
    localparam int NUM_SRC = 12;
    localparam int LVL_W   = 2;

    typedef logic [LVL_W-1:0] lvl_t;

    localparam lvl_t LVL_NONE = 2'd0;
    localparam lvl_t LVL_LOW  = 2'd1;
    localparam lvl_t LVL_HIGH = 2'd2;
    localparam lvl_t LVL_TOP  = 2'd3;

    // Vector index (0-based) that an on-chip strobe feeds.
    function automatic int src_vec(input int s);
        case (s)
            0:       return 2;
            1:       return 3;
            2:       return 4;
            3, 4:    return 5;
            5:       return 6;
            6:       return 7;
            7, 8, 9: return 8;
            default: return 9;
        endcase
    endfunction

    // Tier of a vector from its select bit; top two vectors sit one tier up.
    function automatic lvl_t vec_level(input int v, input logic sel);
        if (v < 2) return sel ? LVL_TOP : LVL_HIGH;
        return sel ? LVL_HIGH : LVL_LOW;
    endfunction

endpackage

// File: rtl/irq_pin_detect.sv
module irq_pin_detect #(
    parameter bit LEVEL_CAPABLE = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  logic [1:0] mode_i,
    output logic       edge_o,
    output logic       level_req_o,
    output logic       level_mode_o
);

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t st_d, st_q;
    logic  rise, fall;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pin_i;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = st_q.s2 & ~st_q.s3;
    assign fall = ~st_q.s2 & st_q.s3;

    generate
        if (LEVEL_CAPABLE) begin : g_level
            always_comb begin
                level_mode_o = mode_i[1];
                level_req_o  = mode_i[1] & (st_q.s2 ^ mode_i[0]);
                case (mode_i)
                    2'b00:   edge_o = rise;
                    2'b01:   edge_o = fall;
                    default: edge_o = 1'b0;
                endcase
            end
        end else begin : g_edge
            always_comb begin
                level_mode_o = 1'b0;
                level_req_o  = 1'b0;
                case (mode_i)
                    2'b00:   edge_o = rise;
                    2'b01:   edge_o = fall;
                    default: edge_o = rise | fall;
                endcase
            end
        end
    endgenerate

    // R3
    level_no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level_mode_o |-> !edge_o);

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int N  = 10,
    parameter int IW = 4
) (
    input  logic [N-1:0] req_i,
    input  lvl_t [N-1:0] lvl_i,
    input  lvl_t         floor_i,
    output logic         found_o,
    output logic [IW-1:0] idx_o,
    output lvl_t         win_lvl_o
);

    always_comb begin
        lvl_t best;
        best    = floor_i;
        found_o = 1'b0;
        idx_o   = '0;
        for (int v = 0; v < N; v++) begin
            if (req_i[v] && (lvl_i[v] > best)) begin
                best    = lvl_i[v];
                found_o = 1'b1;
                idx_o   = IW'(v);
            end
        end
        win_lvl_o = best;
    end

    always_comb begin
        if (found_o) begin
            // R7
            arb_pick_chk: assert (req_i[idx_o] && (lvl_i[idx_o] > floor_i));
        end
    end

endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack
    import irq_pkg::*;
#(
    parameter  int DEPTH = 3,
    localparam int DW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    input  lvl_t          push_lvl_i,
    output lvl_t          cur_lvl_o,
    output logic [DW-1:0] depth_o
);

    typedef struct packed {
        lvl_t [DEPTH-1:0] ent;
        logic [DW-1:0]    sp;
    } stk_t;

    stk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pop_i) begin
            if (st_q.sp != '0) st_d.sp = st_q.sp - 1'b1;
        end else if (push_i && (st_q.sp != DW'(DEPTH))) begin
            st_d.ent[st_q.sp] = push_lvl_i;
            st_d.sp           = st_q.sp + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_lvl_o = (st_q.sp == '0) ? LVL_NONE : st_q.ent[st_q.sp - 1'b1];
    assign depth_o   = st_q.sp;

    // R9
    stack_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i) |-> (st_q.sp != DW'(DEPTH)));

    // R9
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && (st_q.sp == '0)) |=> (st_q.sp == '0));

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_pkg::*;
#(
    parameter int VEC_BASE    = 3,
    parameter int VEC_STRIDE  = 8,
    parameter int STACK_DEPTH = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PIN-1:0]   ext_pin_i,
    input  logic [NUM_SRC-1:0]   src_i,
    input  logic [2*NUM_PIN-1:0] trig_mode_i,
    input  logic [NUM_VEC-1:0]   vec_en_i,
    input  logic [NUM_VEC-1:0]   vec_prio_i,
    input  logic                 ack_i,
    input  logic                 ret_i,
    output logic                 irq_o,
    output logic [7:0]           vec_addr_o,
    output logic                 wake_o
);

    localparam int IW = $clog2(NUM_VEC);
    localparam int DW = $clog2(STACK_DEPTH + 1);

    typedef struct packed {
        logic [NUM_VEC-1:0] pend;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NUM_PIN-1:0] edge_hit, lvl_req, lvl_mode;
    logic [NUM_VEC-1:0] pend_set, pend_clr, req;
    lvl_t [NUM_VEC-1:0] vlvl;
    logic               found, take;
    logic [IW-1:0]      win_idx;
    lvl_t               win_lvl, cur_lvl;
    logic [DW-1:0]      depth;

    genvar gp;
    generate
        for (gp = 0; gp < NUM_PIN; gp++) begin : g_pin
            irq_pin_detect #(.LEVEL_CAPABLE(gp < 2)) pin_i (
                .clk          (clk),
                .rst_n        (rst_n),
                .pin_i        (ext_pin_i[gp]),
                .mode_i       (trig_mode_i[2*gp +: 2]),
                .edge_o       (edge_hit[gp]),
                .level_req_o  (lvl_req[gp]),
                .level_mode_o (lvl_mode[gp])
            );
        end
    endgenerate

    always_comb begin
        for (int v = 0; v < NUM_VEC; v++) vlvl[v] = vec_level(v, vec_prio_i[v]);
    end

    always_comb begin
        req = vec_en_i & (ctl_q.pend | {{(NUM_VEC-NUM_PIN){1'b0}}, lvl_req});
    end

    irq_arbiter #(.N(NUM_VEC), .IW(IW)) arb_i (
        .req_i     (req),
        .lvl_i     (vlvl),
        .floor_i   (cur_lvl),
        .found_o   (found),
        .idx_o     (win_idx),
        .win_lvl_o (win_lvl)
    );

    assign take = ack_i & found & ~ret_i;

    irq_level_stack #(.DEPTH(STACK_DEPTH)) stk_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (take),
        .pop_i      (ret_i),
        .push_lvl_i (win_lvl),
        .cur_lvl_o  (cur_lvl),
        .depth_o    (depth)
    );

    always_comb begin
        pend_set = '0;
        pend_clr = '0;
        for (int p = 0; p < NUM_PIN; p++) pend_set[p] = edge_hit[p];
        for (int s = 0; s < NUM_SRC; s++) begin
            if (src_i[s]) pend_set[src_vec(s)] = 1'b1;
        end
        if (take) pend_clr[win_idx] = 1'b1;

        ctl_d      = ctl_q;
        ctl_d.pend = (ctl_q.pend & ~pend_clr) | pend_set;
        for (int p = 0; p < NUM_PIN; p++) begin
            if (lvl_mode[p]) ctl_d.pend[p] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign irq_o      = found;
    assign vec_addr_o = found ? 8'(VEC_BASE + VEC_STRIDE * int'(win_idx)) : 8'h00;
    assign wake_o     = |req;

    // R10
    irq_implies_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> wake_o);

    // R8
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (vec_addr_o[2:0] == 3'b011));

    // R7
    nest_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (win_lvl > cur_lvl));

    // R9
    ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !irq_o && !ret_i) |=> $stable(depth));

    // R9
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !pend_set[win_idx]) |=> !ctl_q.pend[$past(win_idx)]);

    // R11
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_en_i == '0) |-> (!wake_o && !irq_o));

endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  pin;
    logic [11:0] src;
    logic [7:0]  trig_mode;
    logic [9:0]  vec_en;
    logic [9:0]  vec_prio;
    logic        ack, ret;
    logic        irq, wake;
    logic [7:0]  addr;

    irq_vector_ctrl dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_pin_i   (pin),
        .src_i       (src),
        .trig_mode_i (trig_mode),
        .vec_en_i    (vec_en),
        .vec_prio_i  (vec_prio),
        .ack_i       (ack),
        .ret_i       (ret),
        .irq_o       (irq),
        .vec_addr_o  (addr),
        .wake_o      (wake)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // ---------------- reference model ----------------
    logic       m_s1 [4];
    logic       m_s2 [4];
    logic       m_s3 [4];
    logic [9:0] m_pend;
    int         m_stk [3];
    int         m_sp;

    function automatic int lvl_of(input int v);
        if (v < 2) return vec_prio[v] ? 3 : 2;
        return vec_prio[v] ? 2 : 1;
    endfunction

    function automatic bit lvl_mode(input int v);
        return (v < 2) && trig_mode[2*v+1];
    endfunction

    function automatic bit lvl_req(input int v);
        return lvl_mode(v) && (m_s2[v] != trig_mode[2*v]);
    endfunction

    function automatic bit m_req(input int v);
        return vec_en[v] && (m_pend[v] || lvl_req(v));
    endfunction

    function automatic int m_cur();
        return (m_sp == 0) ? 0 : m_stk[m_sp-1];
    endfunction

    function automatic int m_arb();
        int best = m_cur();
        int w    = -1;
        for (int v = 0; v < 10; v++) begin
            if (m_req(v) && lvl_of(v) > best) begin
                best = lvl_of(v);
                w    = v;
            end
        end
        return w;
    endfunction

    function automatic bit m_edge(input int p);
        bit r = m_s2[p] && !m_s3[p];
        bit f = !m_s2[p] && m_s3[p];
        logic [1:0] md = trig_mode[2*p +: 2];
        if (md == 2'b00) return r;
        if (md == 2'b01) return f;
        if (p < 2) return 1'b0;
        return r || f;
    endfunction

    function automatic int m_src_vec(input int s);
        if (s == 0) return 2;
        if (s == 1) return 3;
        if (s == 2) return 4;
        if (s <= 4) return 5;
        if (s == 5) return 6;
        if (s == 6) return 7;
        if (s <= 9) return 8;
        return 9;
    endfunction

    task automatic model_reset();
        for (int p = 0; p < 4; p++) begin
            m_s1[p] = 1'b0; m_s2[p] = 1'b0; m_s3[p] = 1'b0;
        end
        m_pend = '0;
        m_sp   = 0;
        for (int i = 0; i < 3; i++) m_stk[i] = 0;
    endtask

    task automatic model_clock();
        int         w    = m_arb();
        bit         take = ack && (w >= 0) && !ret;
        logic [9:0] np   = m_pend;
        if (take) np[w] = 1'b0;
        for (int p = 0; p < 4; p++) if (m_edge(p)) np[p] = 1'b1;
        for (int s = 0; s < 12; s++) if (src[s]) np[m_src_vec(s)] = 1'b1;
        for (int p = 0; p < 2; p++) if (lvl_mode(p)) np[p] = 1'b0;
        if (ret) begin
            if (m_sp > 0) m_sp--;
        end else if (take) begin
            m_stk[m_sp] = lvl_of(w);
            m_sp++;
        end
        for (int p = 0; p < 4; p++) begin
            m_s3[p] = m_s2[p];
            m_s2[p] = m_s1[p];
            m_s1[p] = pin[p];
        end
        m_pend = np;
    endtask

    // ---------------- checking ----------------
    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        int w = m_arb();
        bit any = 1'b0;
        for (int v = 0; v < 10; v++) any |= m_req(v);
        check("R7",  "irq_o",      32'(irq),  32'(w >= 0));
        check("R8",  "vec_addr_o", 32'(addr), (w >= 0) ? 32'(3 + 8*w) : 32'd0);
        check("R10", "wake_o",     32'(wake), 32'(any));
    endtask

    task automatic expect_out(input string req, input bit e_irq, input int e_addr);
        check(req, "irq_o",      32'(irq),  32'(e_irq));
        check(req, "vec_addr_o", 32'(addr), 32'(e_addr));
    endtask

    task automatic step();
        @(posedge clk);
        model_clock();
        @(negedge clk);
        compare();
    endtask

    task automatic reset_dut();
        @(negedge clk);
        rst_n = 1'b0;
        pin = '0; src = '0; trig_mode = '0; vec_en = '0; vec_prio = '0;
        ack = 1'b0; ret = 1'b0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // ---------------- stimulus ----------------
    initial begin
        rst_n = 1'b0;
        pin = '0; src = '0; trig_mode = '0; vec_en = '0; vec_prio = '0;
        ack = 1'b0; ret = 1'b0;
        void'($urandom(32'd7321));

        // R1: reset state
        reset_dut();
        expect_out("R1", 1'b0, 0);
        check("R1", "wake_o", 32'(wake), 32'd0);

        // R2: edge pin latency, R8 address of vector 1
        vec_en = '1;
        pin[0] = 1'b1;
        step(); expect_out("R2", 1'b0, 0);
        step(); expect_out("R2", 1'b0, 0);
        step(); expect_out("R2", 1'b1, 'h03);
        ack = 1'b1; step(); ack = 1'b0;
        expect_out("R9", 1'b0, 0);
        // R5 / R7: low-tier strobe blocked by high in service, still wakes
        src[0] = 1'b1; step(); src = '0;
        expect_out("R7", 1'b0, 0);
        check("R10", "wake_o", 32'(wake), 32'd1);
        ret = 1'b1; step(); ret = 1'b0;
        expect_out("R9", 1'b1, 'h13);

        // R3: level mode follows the pin
        reset_dut();
        vec_en = '1;
        trig_mode = 8'b0000_1000;
        pin[1] = 1'b1;
        step(); step(); expect_out("R3", 1'b1, 'h0B);
        pin[1] = 1'b0;
        step(); expect_out("R3", 1'b1, 'h0B);
        step(); expect_out("R3", 1'b0, 0);

        // R4: both-edge mode on pin 2
        reset_dut();
        vec_en = '1;
        trig_mode = 8'b0010_0000;
        pin[2] = 1'b1;
        step(); step(); step(); expect_out("R4", 1'b1, 'h13);
        ack = 1'b1; step(); ack = 1'b0;
        ret = 1'b1; step(); ret = 1'b0;
        expect_out("R4", 1'b0, 0);
        pin[2] = 1'b0;
        step(); step(); expect_out("R4", 1'b0, 0);
        step(); expect_out("R4", 1'b1, 'h13);

        // R11: disabled pending retained
        reset_dut();
        src[5] = 1'b1; step(); src = '0;
        step();
        expect_out("R11", 1'b0, 0);
        check("R11", "wake_o", 32'(wake), 32'd0);
        vec_en[6] = 1'b1;
        step(); expect_out("R11", 1'b1, 'h33);

        // R6 / R7: highest tier preempts, equal tier blocked, tie on pop
        reset_dut();
        vec_en = '1;
        vec_prio = 10'b10_0000_0001;
        src[10] = 1'b1; step(); src = '0;
        expect_out("R5", 1'b1, 'h4B);
        ack = 1'b1; step(); ack = 1'b0;
        pin[0] = 1'b1; pin[1] = 1'b1;
        step(); step(); step();
        expect_out("R6", 1'b1, 'h03);
        ack = 1'b1; step(); ack = 1'b0;
        expect_out("R7", 1'b0, 0);
        ret = 1'b1; step();
        expect_out("R7", 1'b0, 0);
        step(); ret = 1'b0;
        expect_out("R7", 1'b1, 'h0B);

        // R9: ack with no request, ack with return, return on empty
        reset_dut();
        vec_en = '1;
        ack = 1'b1; ret = 1'b1; step(); ack = 1'b0; ret = 1'b0;
        src[6] = 1'b1; step(); src = '0;
        expect_out("R9", 1'b1, 'h3B);
        ack = 1'b1; ret = 1'b1; step(); ack = 1'b0; ret = 1'b0;
        expect_out("R9", 1'b1, 'h3B);
        ack = 1'b1; step(); ack = 1'b0;
        expect_out("R9", 1'b0, 0);

        // random phase
        reset_dut();
        vec_en = 10'($urandom);
        for (int c = 0; c < 4000; c++) begin
            for (int p = 0; p < 4; p++) if ($urandom % 8 == 0) pin[p] = ~pin[p];
            src = '0;
            for (int s = 0; s < 12; s++) if ($urandom % 24 == 0) src[s] = 1'b1;
            ack = ($urandom % 3 == 0);
            ret = ($urandom % 7 == 0);
            if ($urandom % 64 == 0)  vec_en    = 10'($urandom);
            if ($urandom % 97 == 0)  vec_prio  = 10'($urandom);
            if ($urandom % 128 == 0) trig_mode = 8'($urandom);
            step();
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule